// File: doc/BRIEF.md
# Multiply-Accumulate Result Readout with Rounding and Saturation

This block is the last stage between a multiply-accumulate unit's accumulator and a 32-bit data register. Each transfer carries one accumulator value and the four mode bits that govern how it is read. The fractional setting picks fractional or integer interpretation. The unsigned setting picks unsigned integer readout, or half-precision (16-bit) output when the fractional setting is on. The other two bits enable rounding and enable saturation. The stage turns the value into a 32-bit word, and it sets a flag whenever the word is a clamped value rather than the true result.

Fractional readout drops a remainder field. This field is 24 bits wide for 16-bit output and 8 bits wide for 32-bit output. Rounding is to nearest, and ties go to the even result. When saturation is enabled, a value that does not fit the output width is clamped to the largest or smallest signed value. Integer readout always clamps. Signed values clamp to the 32-bit signed limits, and unsigned values clamp to all ones.

A valid/ready pair sits on each side of the stage. There is one register stage, so an accepted value appears one cycle later. The mode bits are captured together with the data.

Top module: `mac_readout`

## Requirements
- R1: The stage asserts `in_ready` exactly when its output register is empty or `out_ready` is high. A value accepted on a rising edge is presented on `out_data` with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `out_data` and `out_ovf` stay unchanged.
- R2: After a synchronous reset, `out_valid`, `out_ovf` and `out_data` are all zero and `in_ready` is high.
- R3: Signed integer readout (`mode_frac`=0, `mode_unsigned`=0) returns `in_acc[31:0]` when bits 47:31 are all equal. Otherwise it returns 0x7FFFFFFF for a positive input and 0x80000000 for a negative one, whatever the value of `mode_sat`.
- R4: Unsigned integer readout (`mode_frac`=0, `mode_unsigned`=1) returns `in_acc[31:0]` when bits 47:32 are zero, and 0xFFFFFFFF otherwise.
- R5: Half-precision fractional readout (`mode_frac`=1, `mode_unsigned`=1) always rounds. It takes the signed field `in_acc[47:24]` and adds one when `in_acc[23:0]` is above 0x800000, or when it equals 0x800000 and the field is odd. The 16-bit result is zero-extended into `out_data`.
- R6: Full-precision fractional readout with rounding (`mode_frac`=1, `mode_unsigned`=0, `mode_round`=1) takes `in_acc` shifted right arithmetically by 8. It adds one when `in_acc[7:0]` is above 0x80, or when it equals 0x80 and the shifted value is odd.
- R7: Full-precision fractional readout with `mode_round`=0 returns `in_acc[39:8]` with no rounding.
- R8: With `mode_sat`=1, a fractional result that does not fit after rounding is clamped. A 16-bit result becomes 0x7FFF or 0x8000, and a 32-bit result becomes 0x7FFFFFFF or 0x80000000, chosen by the sign.
- R9: With `mode_sat`=0, a fractional result is the low 16 or 32 bits of the rounded value, and `out_ovf` is 0.
- R10: `out_ovf` is 1 exactly when the delivered word is a clamp value that replaced the true result.
- R11: The mode bits are sampled only when the data is accepted. Changing them while the output is stalled does not alter the held result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input value and modes are present |
| in_ready | output | 1 | Stage can take a value this cycle |
| in_acc | input | 48 | Accumulator value, two's complement |
| mode_frac | input | 1 | 1: fractional readout, 0: integer readout |
| mode_unsigned | input | 1 | Integer: unsigned readout; fractional: 16-bit output |
| mode_round | input | 1 | Round enable for 32-bit fractional output |
| mode_sat | input | 1 | Saturation enable for fractional output |
| out_valid | output | 1 | Result register holds a value |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Readout result |
| out_ovf | output | 1 | Result was clamped |

## Verification
The bench builds the stage with its default widths: a 48-bit accumulator, a 32-bit result, a 16-bit half precision, and remainders of 8 and 24 bits. With these widths, every clamp boundary can be reached directly from input vectors. This includes a rounding carry that pushes 0x7FFF or 0x7FFFFFFF over the edge, and negative values just below the signed 32-bit limit. Exact ties with both odd and even results can be set up for each remainder width. A stalled output with changed input modes shows that the modes travel with the data.

// File: rtl/mac_rd_pkg.sv
package mac_rd_pkg;
  typedef struct packed {
    logic frac;
    logic uns;
    logic rnd;
    logic sat;
  } rd_mode_t;
endpackage

// File: rtl/mac_rd_frac.sv
// Fractional readout: drop a SHIFT-bit remainder, round to nearest even,
// then clamp to OUT_W signed bits when saturation is enabled.
module mac_rd_frac #(
  parameter int IN_W  = 48,
  parameter int SHIFT = 8,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  acc,
  input  logic             rnd_en,
  input  logic             sat_en,
  output logic [OUT_W-1:0] res,
  output logic             ovf
);
  localparam int Q_W = IN_W - SHIFT;
  localparam logic [SHIFT-1:0] HALF = {1'b1, {(SHIFT-1){1'b0}}};

  logic [Q_W-1:0]   q;
  logic [SHIFT-1:0] rem;
  logic             inc;
  logic [Q_W:0]     sum;
  logic             fits;

  assign q    = acc[IN_W-1:SHIFT];
  assign rem  = acc[SHIFT-1:0];
  assign inc  = rnd_en & ((rem > HALF) | ((rem == HALF) & q[0]));
  assign sum  = {q[Q_W-1], q} + {{Q_W{1'b0}}, inc};
  assign fits = (&sum[Q_W:OUT_W-1]) | ~(|sum[Q_W:OUT_W-1]);

  always_comb begin
    if (sat_en && !fits) begin
      res = sum[Q_W] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
      ovf = 1'b1;
    end else begin
      res = sum[OUT_W-1:0];
      ovf = 1'b0;
    end
  end
endmodule

// File: rtl/mac_rd_int.sv
// Integer readout: signed or unsigned, always clamped when out of range.
module mac_rd_int #(
  parameter int IN_W  = 48,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  acc,
  input  logic             uns,
  output logic [OUT_W-1:0] res,
  output logic             ovf
);
  logic s_fit;
  logic u_fit;

  assign s_fit = (&acc[IN_W-1:OUT_W-1]) | ~(|acc[IN_W-1:OUT_W-1]);
  assign u_fit = ~(|acc[IN_W-1:OUT_W]);

  always_comb begin
    res = acc[OUT_W-1:0];
    ovf = 1'b0;
    if (uns) begin
      if (!u_fit) begin
        res = {OUT_W{1'b1}};
        ovf = 1'b1;
      end
    end else if (!s_fit) begin
      res = acc[IN_W-1] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
      ovf = 1'b1;
    end
  end
endmodule

// File: rtl/mac_readout.sv
module mac_readout #(
  parameter int ACC_W        = 48,
  parameter int DATA_W       = 32,
  parameter int HALF_W       = 16,
  parameter int FINE_SHIFT   = 8,
  parameter int COARSE_SHIFT = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ACC_W-1:0]  in_acc,
  input  logic              mode_frac,
  input  logic              mode_unsigned,
  input  logic              mode_round,
  input  logic              mode_sat,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_ovf
);
  import mac_rd_pkg::*;

  localparam int PAD_W = DATA_W - HALF_W;

  rd_mode_t          mode;
  logic [HALF_W-1:0] r16;
  logic              o16;
  logic [DATA_W-1:0] r32;
  logic              o32;
  logic [DATA_W-1:0] ri;
  logic              oi;
  logic [DATA_W-1:0] nxt_data;
  logic              nxt_ovf;
  logic              take;

  assign mode = '{frac: mode_frac, uns: mode_unsigned, rnd: mode_round, sat: mode_sat};

  // Half precision always rounds.
  mac_rd_frac #(.IN_W(ACC_W), .SHIFT(COARSE_SHIFT), .OUT_W(HALF_W)) u_frac16 (
    .acc(in_acc), .rnd_en(1'b1), .sat_en(mode.sat), .res(r16), .ovf(o16)
  );

  mac_rd_frac #(.IN_W(ACC_W), .SHIFT(FINE_SHIFT), .OUT_W(DATA_W)) u_frac32 (
    .acc(in_acc), .rnd_en(mode.rnd), .sat_en(mode.sat), .res(r32), .ovf(o32)
  );

  mac_rd_int #(.IN_W(ACC_W), .OUT_W(DATA_W)) u_int (
    .acc(in_acc), .uns(mode.uns), .res(ri), .ovf(oi)
  );

  always_comb begin
    if (!mode.frac) begin
      nxt_data = ri;
      nxt_ovf  = oi;
    end else if (mode.uns) begin
      nxt_data = {{PAD_W{1'b0}}, r16};
      nxt_ovf  = o16;
    end else begin
      nxt_data = r32;
      nxt_ovf  = o32;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= nxt_data;
        out_ovf   <= nxt_ovf;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mac_readout_chk.sv
module mac_readout_chk #(
  parameter int ACC_W      = 48,
  parameter int DATA_W     = 32,
  parameter int HALF_W     = 16,
  parameter int FINE_SHIFT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ACC_W-1:0]  in_acc,
  input logic              mode_frac,
  input logic              mode_unsigned,
  input logic              mode_round,
  input logic              mode_sat,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ovf
);
  localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] UMAX = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] HMAX = {{(DATA_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] HMIN = {{(DATA_W-HALF_W){1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};

  logic acc_ok;
  assign acc_ok = in_valid && in_ready;

  p_reset_r2: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_ovf && out_data == '0));

  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    acc_ok |=> out_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ovf)));

  p_sint_fit_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && !mode_frac && !mode_unsigned &&
     ((&in_acc[ACC_W-1:DATA_W-1]) || !(|in_acc[ACC_W-1:DATA_W-1])))
    |=> (out_data == $past(in_acc[DATA_W-1:0]) && !out_ovf));

  p_uint_fit_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && !mode_frac && mode_unsigned && !(|in_acc[ACC_W-1:DATA_W]))
    |=> (out_data == $past(in_acc[DATA_W-1:0]) && !out_ovf));

  p_half_zext_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && mode_frac && mode_unsigned) |=> (out_data[DATA_W-1:HALF_W] == '0));

  p_trunc_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && mode_frac && !mode_unsigned && !mode_round && !mode_sat)
    |=> (out_data == $past(in_acc[FINE_SHIFT+DATA_W-1:FINE_SHIFT])));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && mode_frac && !mode_sat) |=> !out_ovf);

  p_clamp_value_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ovf) |->
      (out_data == SMAX || out_data == SMIN || out_data == UMAX ||
       out_data == HMAX || out_data == HMIN));
endmodule

bind mac_readout mac_readout_chk #(
  .ACC_W(ACC_W), .DATA_W(DATA_W), .HALF_W(HALF_W), .FINE_SHIFT(FINE_SHIFT)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_acc(in_acc),
  .mode_frac(mode_frac), .mode_unsigned(mode_unsigned), .mode_round(mode_round),
  .mode_sat(mode_sat), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_ovf(out_ovf)
);

// File: tb/mac_readout_bench.sv
module mac_readout_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [47:0] in_acc;
  logic        mode_frac, mode_unsigned, mode_round, mode_sat;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic        out_ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mac_readout u_mac_readout (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_acc(in_acc),
    .mode_frac(mode_frac), .mode_unsigned(mode_unsigned), .mode_round(mode_round),
    .mode_sat(mode_sat), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ovf(out_ovf)
  );

  // {frac, uns, rnd, sat, acc[47:0], expected data[31:0], expected ovf}
  localparam int NV = 26;
  localparam logic [84:0] VEC [NV] = '{
    {4'b0000, 48'h0000_1234_5678, 32'h1234_5678, 1'b0},
    {4'b0001, 48'hFFFF_FFFF_FFFE, 32'hFFFF_FFFE, 1'b0},
    {4'b0000, 48'h0000_8000_0000, 32'h7FFF_FFFF, 1'b1},
    {4'b0001, 48'hFFFF_7FFF_FFFF, 32'h8000_0000, 1'b1},
    {4'b0000, 48'hFFFF_8000_0000, 32'h8000_0000, 1'b0},
    {4'b0100, 48'h0000_FFFF_FFFF, 32'hFFFF_FFFF, 1'b0},
    {4'b0100, 48'h0001_0000_0000, 32'hFFFF_FFFF, 1'b1},
    {4'b0101, 48'hFFFF_FFFF_FFFF, 32'hFFFF_FFFF, 1'b1},
    {4'b1101, 48'h0012_3440_0000, 32'h0000_1234, 1'b0},
    {4'b1101, 48'h0012_3480_0001, 32'h0000_1235, 1'b0},
    {4'b1101, 48'h0012_3480_0000, 32'h0000_1234, 1'b0},
    {4'b1101, 48'h0012_3580_0000, 32'h0000_1236, 1'b0},
    {4'b1101, 48'h007F_FF90_0000, 32'h0000_7FFF, 1'b1},
    {4'b1101, 48'hFF00_0000_0000, 32'h0000_8000, 1'b1},
    {4'b1101, 48'hFFFF_FF00_0000, 32'h0000_FFFF, 1'b0},
    {4'b1100, 48'h007F_FF90_0000, 32'h0000_8000, 1'b0},
    {4'b1011, 48'h0000_1234_5681, 32'h0012_3457, 1'b0},
    {4'b1011, 48'h0000_1234_5680, 32'h0012_3456, 1'b0},
    {4'b1011, 48'h0000_1234_5780, 32'h0012_3458, 1'b0},
    {4'b1001, 48'h0000_1234_56FF, 32'h0012_3456, 1'b0},
    {4'b1011, 48'h0080_0000_0000, 32'h7FFF_FFFF, 1'b1},
    {4'b1011, 48'h007F_FFFF_FF90, 32'h7FFF_FFFF, 1'b1},
    {4'b1011, 48'hFF00_0000_0000, 32'h8000_0000, 1'b1},
    {4'b1010, 48'h0080_0000_0000, 32'h8000_0000, 1'b0},
    {4'b1011, 48'hFFFF_FFFF_FF00, 32'hFFFF_FFFF, 1'b0},
    {4'b1000, 48'hFFFF_FFFF_FEFF, 32'hFFFF_FFFE, 1'b0}
  };

  function automatic string tag_of(logic f, logic u, logic r, logic s, logic ov);
    string t;
    if (!f)     t = u ? "R4" : "R3";
    else if (u) t = "R5";
    else if (r) t = "R6";
    else        t = "R7";
    if (f && s && ov) t = {t, "/R8"};
    if (f && !s)      t = {t, "/R9"};
    if (ov)           t = {t, "/R10"};
    return t;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] m, logic [47:0] a);
    {mode_frac, mode_unsigned, mode_round, mode_sat} = m;
    in_acc   = a;
    in_valid = 1'b1;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_acc = '0; out_ready = 1'b1;
    {mode_frac, mode_unsigned, mode_round, mode_sat} = 4'b0000;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R2 out_data", out_data, 32'd0);
    chk("R2 out_ovf", {31'd0, out_ovf}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 in_ready", {31'd0, in_ready}, 32'd1);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][84:81], VEC[i][80:33]);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag_of(VEC[i][84], VEC[i][83], VEC[i][82], VEC[i][81], VEC[i][0]), " data"},
          out_data, VEC[i][32:1]);
      chk({tag_of(VEC[i][84], VEC[i][83], VEC[i][82], VEC[i][81], VEC[i][0]), " ovf"},
          {31'd0, out_ovf}, {31'd0, VEC[i][0]});
      chk("R1 out_valid", {31'd0, out_valid}, 32'd1);
    end

    // Stall and mode capture: R1, R11
    @(negedge clk);
    out_ready = 1'b0;
    drive(4'b0000, 48'h0000_0000_0042);
    @(posedge clk);
    @(negedge clk);
    chk("R1 stalled first data", out_data, 32'h0000_0042);
    chk("R1 in_ready low when full", {31'd0, in_ready}, 32'd0);
    drive(4'b1101, 48'h0012_3580_0000);
    @(posedge clk);
    @(negedge clk);
    chk("R11 held data after mode change", out_data, 32'h0000_0042);
    chk("R11 held ovf", {31'd0, out_ovf}, 32'd0);
    chk("R1 held valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 second value after release", out_data, 32'h0000_1236);
    @(posedge clk);
    @(negedge clk);
    chk("R1 drained", {31'd0, out_valid}, 32'd0);

    // Back-to-back: R1 full throughput, R8 then R3
    drive(4'b1011, 48'hFF00_0000_0000);
    @(posedge clk);
    @(negedge clk);
    chk("R8 back-to-back first", out_data, 32'h8000_0000);
    drive(4'b0000, 48'h0000_0000_0007);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 back-to-back second", out_data, 32'h0000_0007);
    chk("R10 ovf cleared", {31'd0, out_ovf}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule